// File: doc/BRIEF.md
# Disk DMA Command Sequencer

This block is the device-side sequencer that carries a read or write DMA command on a parallel disk interface. The host writes a starting sector address, a sector count and a command code. The sequencer raises the busy flag at once and waits for the media side to report that a sector buffer is ready. It then requests a burst from the host and counts the data words that the host strobes while it holds its DMA acknowledge. Each burst carries one sector. Between sectors the request drops and the busy flag returns while the next buffer is prepared.

From the command write until completion, exactly one of busy or data-request is shown. When the last sector finishes, or when the media side reports an unrecoverable sector failure, both flags clear and one interrupt is raised in the same cycle. The reported sector address is fixed by rule: after success it is the last sector moved, and after an error it is the failing sector. The interrupt holds until the host reads status. A running command can be stopped only by reset.

Top module: `dma_cmd_seq`

## Requirements
- R1: With the sequencer idle, a command write whose code is the read code (0xC8) or the write code (0xCA), with a nonzero sector count, shows busy=1 and drq=0 from the next cycle on. Any other code, or a zero count, leaves busy low.
- R2: In the busy wait, media_rdy sampled high while DMACK is low moves the sequencer to drq=1, busy=0 and DMARQ=1 on the next cycle.
- R3: DMARQ stays high until a word has been taken under DMACK. It falls on the edge that accepts the sector's last word and never falls while DMACK is low.
- R4: A word is accepted only on a rising edge of the strobe that matches the command direction (DIOR for read, DIOW for write) while DMACK is high. The other strobe, or any strobe while DMACK is low, is ignored.
- R5: The DMARQ output enable is high only while the device is selected and a command is in its data phase.
- R6: From the cycle after the command write until the interrupt, exactly one of busy or drq is high.
- R7: After a sector that is not the last, the sequencer returns to busy=1, drq=0, DMARQ=0, and the reported address advances by one.
- R8: Each command raises the interrupt exactly once, in the cycle where busy and drq both clear. No interrupt is raised per sector.
- R9: On success the reported address equals start + count - 1 and the error flag is low.
- R10: media_err sampled in the busy wait ends the command. The reported address is that sector's address and the error flag is high.
- R11: Command writes during the data phase change neither the address nor the sequence.
- R12: The interrupt holds until a status read clears it. A status read in the same cycle as a valid new command write clears the interrupt and starts the new command.
- R13: Reset clears busy, drq, interrupt, error, the DMARQ enable and any partly counted sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Device is selected |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 8 | Command code |
| start_lba | input | LBA_W | Starting sector address |
| sec_count | input | CNT_W | Number of sectors |
| status_rd | input | 1 | Host status read, clears the interrupt |
| media_rdy | input | 1 | Media side has a sector buffer ready |
| media_err | input | 1 | Media side reports an unrecoverable sector failure |
| dmack | input | 1 | Host DMA acknowledge |
| dior | input | 1 | Host read strobe |
| diow | input | 1 | Host write strobe |
| bsy | output | 1 | Busy status |
| drq | output | 1 | Data request status |
| intrq | output | 1 | Interrupt request |
| err | output | 1 | Error status |
| dmarq_oe | output | 1 | Drive enable for the DMA request line |
| dmarq | output | 1 | DMA request value |
| xfer_word | output | 1 | One data word accepted this cycle |
| cur_lba | output | LBA_W | Current or reported sector address |

## Verification
Two events can meet in one cycle: the host's status read, which clears the pending interrupt, and a valid command write, which starts the next command. The bench completes a command without reading status, then asserts both strobes on the same clock. It expects the interrupt low and busy high on the next cycle, and then runs the new command to completion. A second overlap is a command write landing in the busy wait of a running command. The bench judges this by the final reported address and a single interrupt.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dmaseq_strobe.sv
module dmaseq_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic is_write,
    input  logic dmack,
    input  logic dior,
    input  logic diow,
    output logic word_ok
);
    typedef struct packed {
        logic rd;
        logic wr;
    } edge_t;

    edge_t st_d, st_q;
    logic  rd_rise, wr_rise;

    always_comb begin
        st_d    = st_q;
        st_d.rd = dior;
        st_d.wr = diow;
        rd_rise = dior & ~st_q.rd;
        wr_rise = diow & ~st_q.wr;
        word_ok = en & dmack & (is_write ? wr_rise : rd_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dmaseq_wordcnt.sv
module dmaseq_wordcnt #(
    parameter int WPS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic word_ok,
    output logic last_word
);
    localparam int CW = (WPS > 1) ? $clog2(WPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WPS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_word = word_ok && (cnt_q == LAST);
        cnt_d     = cnt_q;
        if (clr)            cnt_d = '0;
        else if (last_word) cnt_d = '0;
        else if (word_ok)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the counter never runs past the sector size
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
    import dmaseq_pkg::*;
#(
    parameter int          LBA_W   = 28,
    parameter int          CNT_W   = 8,
    parameter logic [7:0]  RD_CODE = 8'hC8,
    parameter logic [7:0]  WR_CODE = 8'hCA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic [LBA_W-1:0] start_lba,
    input  logic [CNT_W-1:0] sec_count,
    input  logic             status_rd,
    input  logic             media_rdy,
    input  logic             media_err,
    input  logic             dmack,
    input  logic             last_word,
    output logic             bsy,
    output logic             drq,
    output logic             intrq,
    output logic             err,
    output logic             dmarq,
    output logic             active,
    output logic             in_burst,
    output logic             is_write,
    output logic [LBA_W-1:0] cur_lba
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        seq_state_e       state;
        logic [LBA_W-1:0] lba;
        logic [CNT_W-1:0] rem;
        logic             wr;
        logic             bsy;
        logic             drq;
        logic             intrq;
        logic             err;
        logic             dmarq;
    } ctrl_t;

    ctrl_t q, d;
    logic  cmd_ok;

    always_comb begin
        d      = q;
        cmd_ok = cmd_we && ((cmd_code == RD_CODE) || (cmd_code == WR_CODE))
                 && (sec_count != '0);
        unique case (q.state)
            ST_IDLE, ST_DONE: begin
                if (cmd_ok) begin
                    d.state = ST_WAIT;
                    d.lba   = start_lba;
                    d.rem   = sec_count;
                    d.wr    = (cmd_code == WR_CODE);
                    d.bsy   = 1'b1;
                    d.drq   = 1'b0;
                    d.intrq = 1'b0;
                    d.err   = 1'b0;
                    d.dmarq = 1'b0;
                end else if (q.state == ST_DONE && status_rd) begin
                    d.state = ST_IDLE;
                    d.intrq = 1'b0;
                end
            end
            ST_WAIT: begin
                if (media_err) begin
                    d.state = ST_DONE;
                    d.bsy   = 1'b0;
                    d.intrq = 1'b1;
                    d.err   = 1'b1;
                end else if (media_rdy && !dmack) begin
                    d.state = ST_BURST;
                    d.bsy   = 1'b0;
                    d.drq   = 1'b1;
                    d.dmarq = 1'b1;
                end
            end
            ST_BURST: begin
                if (last_word) begin
                    d.drq   = 1'b0;
                    d.dmarq = 1'b0;
                    if (q.rem == ONE) begin
                        d.state = ST_DONE;
                        d.intrq = 1'b1;
                    end else begin
                        d.state = ST_WAIT;
                        d.bsy   = 1'b1;
                        d.rem   = q.rem - ONE;
                        d.lba   = q.lba + 1'b1;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign bsy      = q.bsy;
    assign drq      = q.drq;
    assign intrq    = q.intrq;
    assign err      = q.err;
    assign dmarq    = q.dmarq;
    assign is_write = q.wr;
    assign cur_lba  = q.lba;
    assign active   = (q.state == ST_WAIT) || (q.state == ST_BURST);
    assign in_burst = (q.state == ST_BURST);

    // R6: exactly one of busy and data request during the data phase
    a_r6_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (q.bsy ^ q.drq));

    // R8: the interrupt rises only as the data phase status clears
    a_r8_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.intrq) |-> (!q.bsy && !q.drq && $past(q.bsy || q.drq)));

    // R3: the request never drops without the host acknowledge
    a_r3_req_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.dmarq) |-> $past(dmack));

    // R2: the request is only raised alongside data request
    a_r2_req_with_drq: assert property (@(posedge clk) disable iff (!rst_n)
        q.dmarq |-> (q.drq && !q.bsy));

    // R11: a command write mid-phase leaves address and count alone
    a_r11_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd_we && !last_word) |=> ($stable(q.lba) && $stable(q.rem)));
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq #(
    parameter int         LBA_W   = 28,
    parameter int         CNT_W   = 8,
    parameter int         WPS     = 256,
    parameter logic [7:0] RD_CODE = 8'hC8,
    parameter logic [7:0] WR_CODE = 8'hCA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic [LBA_W-1:0] start_lba,
    input  logic [CNT_W-1:0] sec_count,
    input  logic             status_rd,
    input  logic             media_rdy,
    input  logic             media_err,
    input  logic             dmack,
    input  logic             dior,
    input  logic             diow,
    output logic             bsy,
    output logic             drq,
    output logic             intrq,
    output logic             err,
    output logic             dmarq_oe,
    output logic             dmarq,
    output logic             xfer_word,
    output logic [LBA_W-1:0] cur_lba
);
    logic active, in_burst, is_write, word_ok, last_word, req_q;

    dmaseq_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (in_burst),
        .is_write (is_write),
        .dmack    (dmack),
        .dior     (dior),
        .diow     (diow),
        .word_ok  (word_ok)
    );

    dmaseq_wordcnt #(.WPS(WPS)) u_wordcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!in_burst),
        .word_ok   (word_ok),
        .last_word (last_word)
    );

    dmaseq_ctrl #(
        .LBA_W   (LBA_W),
        .CNT_W   (CNT_W),
        .RD_CODE (RD_CODE),
        .WR_CODE (WR_CODE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_code  (cmd_code),
        .start_lba (start_lba),
        .sec_count (sec_count),
        .status_rd (status_rd),
        .media_rdy (media_rdy),
        .media_err (media_err),
        .dmack     (dmack),
        .last_word (last_word),
        .bsy       (bsy),
        .drq       (drq),
        .intrq     (intrq),
        .err       (err),
        .dmarq     (req_q),
        .active    (active),
        .in_burst  (in_burst),
        .is_write  (is_write),
        .cur_lba   (cur_lba)
    );

    assign dmarq_oe  = sel & active;
    assign dmarq     = sel & req_q;
    assign xfer_word = word_ok;

    // R4: a counted word always comes from a burst
    a_r4_word_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_word |-> (drq && !bsy));
endmodule

// File: tb/test_dma_cmd_seq.sv
module test_dma_cmd_seq;
    localparam int LBA_W = 28;
    localparam int CNT_W = 8;
    localparam int WPS   = 4;
    localparam logic [7:0] RD = 8'hC8;
    localparam logic [7:0] WR = 8'hCA;
    localparam logic [7:0] NOERR = 8'hFF;

    typedef struct packed {
        logic             wr;
        logic [LBA_W-1:0] start;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       errsec;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{wr: 1'b0, start: 28'd100,     cnt: 8'd1, errsec: 8'hFF},
        '{wr: 1'b1, start: 28'hFFFFFFE, cnt: 8'd2, errsec: 8'hFF},
        '{wr: 1'b0, start: 28'd5,       cnt: 8'd4, errsec: 8'd2},
        '{wr: 1'b1, start: 28'd50,      cnt: 8'd2, errsec: 8'd0},
        '{wr: 1'b0, start: 28'd0,       cnt: 8'd3, errsec: 8'hFF}
    };

    logic clk = 0, rst_n = 0, sel = 1, cmd_we = 0, status_rd = 0;
    logic media_rdy = 0, media_err = 0, dmack = 0, dior = 0, diow = 0;
    logic [7:0] cmd_code = 0;
    logic [LBA_W-1:0] start_lba = 0;
    logic [CNT_W-1:0] sec_count = 0;
    logic bsy, drq, intrq, err, dmarq_oe, dmarq, xfer_word;
    logic [LBA_W-1:0] cur_lba;

    int n_chk = 0, n_fail = 0, irq_rises = 0, r6_bad = 0, cyc = 0;
    logic irq_prev = 0, in_cmd = 0;

    always #5 clk = ~clk;

    dma_cmd_seq #(.LBA_W(LBA_W), .CNT_W(CNT_W), .WPS(WPS)) i_dma_cmd_seq (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .start_lba(start_lba), .sec_count(sec_count), .status_rd(status_rd),
        .media_rdy(media_rdy), .media_err(media_err), .dmack(dmack), .dior(dior),
        .diow(diow), .bsy(bsy), .drq(drq), .intrq(intrq), .err(err),
        .dmarq_oe(dmarq_oe), .dmarq(dmarq), .xfer_word(xfer_word), .cur_lba(cur_lba)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (intrq && !irq_prev) irq_rises++;
            if (in_cmd && !intrq && !(bsy ^ drq)) r6_bad++;
        end
        irq_prev = intrq;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_cmd(input logic [7:0] code, input logic [LBA_W-1:0] a, input logic [CNT_W-1:0] n);
        cmd_we = 1; cmd_code = code; start_lba = a; sec_count = n;
    endtask

    task automatic run_cmd(input logic wr, input logic [LBA_W-1:0] a, input logic [CNT_W-1:0] n,
                           input logic [7:0] errsec, input bit skip_issue, input bit no_ack);
        int base;
        bit hit_err;
        logic [LBA_W-1:0] exp_lba;
        base = irq_rises;
        hit_err = 0;
        if (!skip_issue) begin
            @(negedge clk); put_cmd(wr ? WR : RD, a, n);
            @(negedge clk); cmd_we = 0;
            chk(bsy == 1 && drq == 0, "R1 busy after command", {bsy, drq}, 2'b10);
        end
        in_cmd = 1;
        for (int s = 0; s < int'(n); s++) begin
            chk(bsy && !drq && !dmarq, "R7 wait state", {bsy, drq, dmarq}, 3'b100);
            chk(cur_lba == a + LBA_W'(s), "R7 address", cur_lba, a + LBA_W'(s));
            if (s == 0) begin
                put_cmd(wr ? RD : WR, 28'h55, 8'd9);
                @(negedge clk); cmd_we = 0;
                chk(bsy == 1 && cur_lba == a, "R11 command ignored", cur_lba, a);
                sel = 0; #1;
                chk(dmarq_oe == 0, "R5 deselected", dmarq_oe, 0);
                sel = 1; #1;
                chk(dmarq_oe == 1, "R5 selected active", dmarq_oe, 1);
            end
            if (s == int'(errsec)) begin
                media_err = 1; @(negedge clk); media_err = 0;
                hit_err = 1;
                break;
            end
            media_rdy = 1; @(negedge clk); media_rdy = 0;
            chk(drq && !bsy && dmarq, "R2 burst start", {bsy, drq, dmarq}, 3'b011);
            if (s == 0) begin
                dmack = 1;
                if (wr) dior = 1; else diow = 1;
                #1 chk(xfer_word == 0, "R4 wrong strobe", xfer_word, 0);
                @(negedge clk); dior = 0; diow = 0; dmack = 0;
                if (wr) diow = 1; else dior = 1;
                #1 chk(xfer_word == 0, "R4 strobe without ack", xfer_word, 0);
                @(negedge clk); dior = 0; diow = 0;
                chk(dmarq == 1, "R3 request held without ack", dmarq, 1);
            end
            dmack = 1; @(negedge clk);
            for (int w = 0; w < WPS; w++) begin
                if (wr) diow = 1; else dior = 1;
                #1 chk(xfer_word == 1, "R4 word taken", xfer_word, 1);
                @(negedge clk); dior = 0; diow = 0;
                chk(dmarq == (w != WPS - 1), "R3 request per word", dmarq, (w != WPS - 1));
                @(negedge clk);
            end
            dmack = 0;
        end
        @(negedge clk);
        exp_lba = hit_err ? a + LBA_W'(errsec) : a + LBA_W'(n) - 1'b1;
        chk(intrq && !bsy && !drq, "R8 end status", {intrq, bsy, drq}, 3'b100);
        chk(irq_rises - base == 1, "R8 single interrupt", irq_rises - base, 1);
        chk(cur_lba == exp_lba, hit_err ? "R10 error address" : "R9 final address", cur_lba, exp_lba);
        chk(err == hit_err, hit_err ? "R10 error flag" : "R9 error flag", err, hit_err);
        chk(r6_bad == 0, "R6 status never idle", r6_bad, 0);
        in_cmd = 0;
        if (!no_ack) begin
            @(negedge clk);
            chk(intrq == 1, "R12 interrupt held", intrq, 1);
            status_rd = 1; @(negedge clk); status_rd = 0;
            chk(intrq == 0 && bsy == 0, "R12 status read clears", {intrq, bsy}, 0);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 50000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({bsy, drq, intrq, err, dmarq_oe} == 0, "R13 reset state", {bsy, drq, intrq, err, dmarq_oe}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(dmarq_oe == 0, "R5 idle no enable", dmarq_oe, 0);

        for (int v = 0; v < NV; v++)
            run_cmd(VECS[v].wr, VECS[v].start, VECS[v].cnt, VECS[v].errsec, 0, 0);

        // R1: unknown code and zero count are ignored
        @(negedge clk); put_cmd(8'h20, 28'd1, 8'd1);
        @(negedge clk); cmd_we = 0;
        chk(bsy == 0, "R1 unknown code ignored", bsy, 0);
        put_cmd(RD, 28'd1, 8'd0);
        @(negedge clk); cmd_we = 0;
        chk(bsy == 0, "R1 zero count ignored", bsy, 0);

        // R12: status read and new command in the same cycle
        run_cmd(0, 28'd200, 8'd1, NOERR, 0, 1);
        @(negedge clk);
        put_cmd(WR, 28'd300, 8'd2); status_rd = 1;
        @(negedge clk); cmd_we = 0; status_rd = 0;
        chk(intrq == 0 && bsy == 1, "R12 read with new command", {intrq, bsy}, 2'b01);
        run_cmd(1, 28'd300, 8'd2, NOERR, 1, 0);

        // R13: reset in the middle of a burst
        @(negedge clk); put_cmd(RD, 28'd7, 8'd2);
        @(negedge clk); cmd_we = 0; media_rdy = 1;
        @(negedge clk); media_rdy = 0; dmack = 1;
        @(negedge clk); dior = 1;
        @(negedge clk); dior = 0; dmack = 0;
        rst_n = 0; #1;
        chk({bsy, drq, intrq, err, dmarq_oe} == 0, "R13 reset mid burst", {bsy, drq, intrq, err, dmarq_oe}, 0);
        @(negedge clk); rst_n = 1;
        run_cmd(0, 28'd9, 8'd1, NOERR, 0, 0);

        finish_run();
    end
endmodule